// File: doc/BRIEF.md
# Inter-Processor Signaling Mailbox

This block lets two processors signal each other over a configurable number of bidirectional channels. It carries no payload. Message data lives in a shared memory outside the block, and the block only tracks whether each message slot is waiting or has been consumed. Each channel is made of two one-way subchannels: one from processor 1 to processor 2, and one from processor 2 to processor 1. Each subchannel holds a single flag that is either free or occupied. Only the sending side may mark a subchannel occupied, and only the receiving side may return it to free.

Each processor has its own write port and its own status outputs. A write carries a 2-bit operation code and a channel-wide data vector. The codes are: 0 sets the processor's outgoing flags, 1 clears its incoming flags, 2 loads its receive-interrupt enables and 3 loads its transmit-interrupt enables.

Each processor has two registered interrupt lines. The receive line is asserted while any enabled incoming subchannel is occupied. The transmit line is asserted while any enabled outgoing subchannel is free. Both lines are ORed across all channels.

Top module: `ipc_mailbox`

## Requirements
- R1: The channel count is the parameter NCH, and instances with 4, 6 and 16 channels are supported. The two subchannels of a channel are independent, and the outgoing status one processor sees equals the incoming status the other processor sees.
- R2: A write with op 0 (set) sets each outgoing flag whose data bit is 1 to occupied, from the next cycle on. Data bits that are 0 leave their flags unchanged.
- R3: A processor's set never changes its incoming flags, and its clear never changes its outgoing flags. A clear therefore cannot free a subchannel on the sending side.
- R4: A write with op 1 (clear) returns each incoming flag whose data bit is 1 to free, from the next cycle on. If a set and a clear reach the same subchannel in the same cycle, the flag ends up free.
- R5: The receive interrupt of a processor equals, one cycle late, the OR over channels of (incoming flag occupied AND receive enable bit).
- R6: The transmit interrupt of a processor equals, one cycle late, the OR over channels of (outgoing flag free AND transmit enable bit).
- R7: Op 2 replaces the receive-enable vector and op 3 replaces the transmit-enable vector of the writing processor. Enables do not change the status outputs.
- R8: After reset all flags are free (status 0), all enable bits are 0 and both interrupt lines of both processors are low.
- R9: While wr_en is low, the write data and op code have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p1_wr_en | input | 1 | Processor 1 write strobe |
| p1_wr_op | input | 2 | Processor 1 operation: 0 set, 1 clear, 2 rx enables, 3 tx enables |
| p1_wr_data | input | NCH | Processor 1 per-channel write data |
| p1_tx_flags | output | NCH | Flags from processor 1 to processor 2 (1 = occupied) |
| p1_rx_flags | output | NCH | Flags from processor 2 to processor 1 (1 = occupied) |
| p1_irq_rx | output | 1 | Processor 1 receive-occupied interrupt |
| p1_irq_tx | output | 1 | Processor 1 transmit-free interrupt |
| p2_wr_en | input | 1 | Processor 2 write strobe |
| p2_wr_op | input | 2 | Processor 2 operation code |
| p2_wr_data | input | NCH | Processor 2 per-channel write data |
| p2_tx_flags | output | NCH | Flags from processor 2 to processor 1 (1 = occupied) |
| p2_rx_flags | output | NCH | Flags from processor 1 to processor 2 (1 = occupied) |
| p2_irq_rx | output | 1 | Processor 2 receive-occupied interrupt |
| p2_irq_tx | output | 1 | Processor 2 transmit-free interrupt |

## Verification
The assertions assume that the write inputs are stable and well defined at each rising edge while reset is low. They need nothing else from the two processors: any mix of simultaneous writes, including a set and a clear aimed at the same subchannel, is legal and is checked. The bench drives every input at the falling edge only. It covers directed cases first and then random operations on both ports in the same cycles, so every collision of codes and channels the assertions reason about can occur.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_CLR  = 2'd1,
    OP_RXEN = 2'd2,
    OP_TXEN = 2'd3
  } mbx_op_e;
endpackage

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_op,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] set_vec,
  output logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] rx_en,
  output logic [NCH-1:0] tx_en
);
  import ipc_mbx_pkg::*;

  mbx_op_e op;
  assign op = mbx_op_e'(wr_op);

  // Set acts only on outgoing flags and clear only on incoming flags (R3)
  always_comb begin
    set_vec = (wr_en && op == OP_SET) ? wr_data : '0;
    clr_vec = (wr_en && op == OP_CLR) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en <= '0;
      tx_en <= '0;
    end else if (wr_en) begin
      if (op == OP_RXEN) rx_en <= wr_data;
      if (op == OP_TXEN) tx_en <= wr_data;
    end
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] flags
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)               flags[ch] <= 1'b0;
      else if (clr_vec[ch])  flags[ch] <= 1'b0;  // clear takes priority
      else if (set_vec[ch])  flags[ch] <= 1'b1;
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] in_flags,
  input  logic [NCH-1:0] rx_en,
  input  logic [NCH-1:0] out_flags,
  input  logic [NCH-1:0] tx_en,
  output logic           irq_rx,
  output logic           irq_tx
);
  logic [NCH-1:0] rx_hit, tx_hit;
  assign rx_hit = in_flags & rx_en;
  assign tx_hit = ~out_flags & tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else begin
      irq_rx <= |rx_hit;
      irq_tx <= |tx_hit;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           p1_wr_en,
  input  logic [1:0]     p1_wr_op,
  input  logic [NCH-1:0] p1_wr_data,
  output logic [NCH-1:0] p1_tx_flags,
  output logic [NCH-1:0] p1_rx_flags,
  output logic           p1_irq_rx,
  output logic           p1_irq_tx,
  input  logic           p2_wr_en,
  input  logic [1:0]     p2_wr_op,
  input  logic [NCH-1:0] p2_wr_data,
  output logic [NCH-1:0] p2_tx_flags,
  output logic [NCH-1:0] p2_rx_flags,
  output logic           p2_irq_rx,
  output logic           p2_irq_tx
);
  logic [NCH-1:0] p1_set, p1_clr, p1_rxen, p1_txen;
  logic [NCH-1:0] p2_set, p2_clr, p2_rxen, p2_txen;
  logic [NCH-1:0] flags_12, flags_21;

  mbx_port_ctrl #(.NCH(NCH)) u_ctrl1 (
    .clk(clk), .rst(rst), .wr_en(p1_wr_en), .wr_op(p1_wr_op), .wr_data(p1_wr_data),
    .set_vec(p1_set), .clr_vec(p1_clr), .rx_en(p1_rxen), .tx_en(p1_txen));

  mbx_port_ctrl #(.NCH(NCH)) u_ctrl2 (
    .clk(clk), .rst(rst), .wr_en(p2_wr_en), .wr_op(p2_wr_op), .wr_data(p2_wr_data),
    .set_vec(p2_set), .clr_vec(p2_clr), .rx_en(p2_rxen), .tx_en(p2_txen));

  // Direction 1->2: processor 1 sets, processor 2 clears
  mbx_flag_bank #(.NCH(NCH)) u_bank12 (
    .clk(clk), .rst(rst), .set_vec(p1_set), .clr_vec(p2_clr), .flags(flags_12));

  // Direction 2->1: processor 2 sets, processor 1 clears
  mbx_flag_bank #(.NCH(NCH)) u_bank21 (
    .clk(clk), .rst(rst), .set_vec(p2_set), .clr_vec(p1_clr), .flags(flags_21));

  mbx_irq_gen #(.NCH(NCH)) u_irq1 (
    .clk(clk), .rst(rst), .in_flags(flags_21), .rx_en(p1_rxen),
    .out_flags(flags_12), .tx_en(p1_txen), .irq_rx(p1_irq_rx), .irq_tx(p1_irq_tx));

  mbx_irq_gen #(.NCH(NCH)) u_irq2 (
    .clk(clk), .rst(rst), .in_flags(flags_12), .rx_en(p2_rxen),
    .out_flags(flags_21), .tx_en(p2_txen), .irq_rx(p2_irq_rx), .irq_tx(p2_irq_tx));

  assign p1_tx_flags = flags_12;
  assign p1_rx_flags = flags_21;
  assign p2_tx_flags = flags_21;
  assign p2_rx_flags = flags_12;
endmodule

// File: rtl/ipc_mbx_chk.sv
module ipc_mbx_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           p1_wr_en,
  input logic [1:0]     p1_wr_op,
  input logic [NCH-1:0] p1_wr_data,
  input logic [NCH-1:0] p1_tx_flags,
  input logic [NCH-1:0] p1_rx_flags,
  input logic           p1_irq_rx,
  input logic           p1_irq_tx,
  input logic           p2_wr_en,
  input logic [1:0]     p2_wr_op,
  input logic [NCH-1:0] p2_wr_data,
  input logic [NCH-1:0] p2_tx_flags,
  input logic [NCH-1:0] p2_rx_flags,
  input logic           p2_irq_rx,
  input logic           p2_irq_tx
);
  logic [NCH-1:0] s12, c12, s21, c21;
  assign s12 = (p1_wr_en && p1_wr_op == 2'd0) ? p1_wr_data : '0;
  assign c12 = (p2_wr_en && p2_wr_op == 2'd1) ? p2_wr_data : '0;
  assign s21 = (p2_wr_en && p2_wr_op == 2'd0) ? p2_wr_data : '0;
  assign c21 = (p1_wr_en && p1_wr_op == 2'd1) ? p1_wr_data : '0;

  AST_VIEW_MATCH: assert property (@(posedge clk) disable iff (rst)
    (p1_tx_flags == p2_rx_flags) && (p2_tx_flags == p1_rx_flags));  // R1

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((p1_tx_flags & ($past(s12) & ~$past(c12))) == ($past(s12) & ~$past(c12))));  // R2

  AST_NO_FOREIGN_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((p1_tx_flags & ~$past(p1_tx_flags) & ~$past(s12)) == '0)
          && ((p2_tx_flags & ~$past(p2_tx_flags) & ~$past(s21)) == '0));  // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((p1_tx_flags & $past(c12)) == '0) && ((p2_tx_flags & $past(c21)) == '0));  // R4

  AST_RX_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(p1_rx_flags) == '0) -> !p1_irq_rx)
          && (($past(p2_rx_flags) == '0) -> !p2_irq_rx));  // R5

  AST_TX_FULL_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(p1_tx_flags) == '1) -> !p1_irq_tx)
          && (($past(p2_tx_flags) == '1) -> !p2_irq_tx));  // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!p1_wr_en && !p2_wr_en) |=> $stable(p1_tx_flags) && $stable(p2_tx_flags));  // R9
endmodule

bind ipc_mailbox ipc_mbx_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  localparam int NCH = 6;
  localparam logic [NCH-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic           p1_wr_en = 1'b0, p2_wr_en = 1'b0;
  logic [1:0]     p1_wr_op = 2'd0, p2_wr_op = 2'd0;
  logic [NCH-1:0] p1_wr_data = '0, p2_wr_data = '0;
  logic [NCH-1:0] p1_tx_flags, p1_rx_flags, p2_tx_flags, p2_rx_flags;
  logic p1_irq_rx, p1_irq_tx, p2_irq_rx, p2_irq_tx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [NCH-1:0] m12 = '0, m21 = '0, r1 = '0, t1 = '0, r2 = '0, t2 = '0;
  bit ei1rx = 0, ei1tx = 0, ei2rx = 0, ei2tx = 0;

  always #10 clk = ~clk;

  ipc_mailbox #(.NCH(NCH)) u_ipc_mailbox (.*);

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(p1_tx_flags == m12, "R2 p1_tx_flags", 32'(p1_tx_flags), 32'(m12));
    chk(p2_rx_flags == m12, "R1 p2_rx_flags", 32'(p2_rx_flags), 32'(m12));
    chk(p2_tx_flags == m21, "R4 p2_tx_flags", 32'(p2_tx_flags), 32'(m21));
    chk(p1_rx_flags == m21, "R1 p1_rx_flags", 32'(p1_rx_flags), 32'(m21));
    chk(p1_irq_rx == ei1rx, "R5 p1_irq_rx", 32'(p1_irq_rx), 32'(ei1rx));
    chk(p2_irq_rx == ei2rx, "R5 p2_irq_rx", 32'(p2_irq_rx), 32'(ei2rx));
    chk(p1_irq_tx == ei1tx, "R6 p1_irq_tx", 32'(p1_irq_tx), 32'(ei1tx));
    chk(p2_irq_tx == ei2tx, "R6 p2_irq_tx", 32'(p2_irq_tx), 32'(ei2tx));
  endtask

  // drive one cycle of writes on both ports, advance the model, compare
  task automatic drive(input bit e1, input logic [1:0] o1, input logic [NCH-1:0] d1,
                       input bit e2, input logic [1:0] o2, input logic [NCH-1:0] d2);
    logic [NCH-1:0] s12, c12, s21, c21;
    p1_wr_en = e1; p1_wr_op = o1; p1_wr_data = d1;
    p2_wr_en = e2; p2_wr_op = o2; p2_wr_data = d2;
    @(posedge clk);
    ei1rx = |(m21 & r1);  ei1tx = |(~m12 & t1);
    ei2rx = |(m12 & r2);  ei2tx = |(~m21 & t2);
    s12 = (e1 && o1 == 2'd0) ? d1 : '0;
    c21 = (e1 && o1 == 2'd1) ? d1 : '0;
    s21 = (e2 && o2 == 2'd0) ? d2 : '0;
    c12 = (e2 && o2 == 2'd1) ? d2 : '0;
    m12 = (m12 | s12) & ~c12;
    m21 = (m21 | s21) & ~c21;
    if (e1 && o1 == 2'd2) r1 = d1;
    if (e1 && o1 == 2'd3) t1 = d1;
    if (e2 && o2 == 2'd2) r2 = d2;
    if (e2 && o2 == 2'd3) t2 = d2;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    chk(p1_tx_flags == '0 && p2_tx_flags == '0, "R8 flags after reset",
        32'({p1_tx_flags, p2_tx_flags}), 32'd0);
    chk(!p1_irq_rx && !p1_irq_tx && !p2_irq_rx && !p2_irq_tx, "R8 irqs after reset",
        32'({p1_irq_rx, p1_irq_tx, p2_irq_rx, p2_irq_tx}), 32'd0);
    compare_all();

    // R2: set from processor 1, bits 0 and 2
    drive(1'b1, 2'd0, 6'b000101, 1'b0, 2'd0, '0);
    chk(p1_tx_flags == 6'b000101, "R2 set marks occupied", 32'(p1_tx_flags), 32'h5);
    chk(p2_tx_flags == '0, "R1 other direction untouched", 32'(p2_tx_flags), 32'h0);

    // R3: processor 1 clear cannot free its own outgoing flags
    drive(1'b1, 2'd1, 6'b000101, 1'b0, 2'd0, '0);
    chk(p1_tx_flags == 6'b000101, "R3 sender clear ignored", 32'(p1_tx_flags), 32'h5);

    // R3: processor 2 set does not touch its incoming flags
    drive(1'b0, 2'd0, '0, 1'b1, 2'd0, 6'b110000);
    chk(p2_rx_flags == 6'b000101, "R3 receiver set ignored", 32'(p2_rx_flags), 32'h5);
    chk(p2_tx_flags == 6'b110000, "R2 p2 set", 32'(p2_tx_flags), 32'h30);

    // R5, R7: enable processor 2 receive interrupts
    drive(1'b0, 2'd0, '0, 1'b1, 2'd2, ALL);
    idle();
    chk(p2_irq_rx == 1'b1, "R5 rx irq with enable", 32'(p2_irq_rx), 32'h1);

    // R6: processor 1 transmit enables on an occupied channel only, then all
    drive(1'b1, 2'd3, 6'b000001, 1'b0, 2'd0, '0);
    idle();
    chk(p1_irq_tx == 1'b0, "R6 tx irq off, channel occupied", 32'(p1_irq_tx), 32'h0);
    drive(1'b1, 2'd3, ALL, 1'b0, 2'd0, '0);
    idle();
    chk(p1_irq_tx == 1'b1, "R6 tx irq on, free channel enabled", 32'(p1_irq_tx), 32'h1);

    // R4: set and clear collide on channel 1
    drive(1'b1, 2'd0, 6'b000010, 1'b1, 2'd1, 6'b000010);
    chk(p1_tx_flags[1] == 1'b0, "R4 clear wins", 32'(p1_tx_flags), 32'(m12));
    // R4: plain clear of channel 0
    drive(1'b0, 2'd0, '0, 1'b1, 2'd1, 6'b000001);
    chk(p1_tx_flags == 6'b000100, "R4 receiver clear frees", 32'(p1_tx_flags), 32'h4);

    // R9: strobe low with live data
    drive(1'b0, 2'd0, ALL, 1'b0, 2'd1, ALL);
    chk(p1_tx_flags == 6'b000100 && p2_tx_flags == 6'b110000, "R9 no write when idle",
        32'({p1_tx_flags, p2_tx_flags}), 32'({6'b000100, 6'b110000}));

    // R7: enables leave status alone
    drive(1'b1, 2'd2, ALL, 1'b1, 2'd3, 6'b001100);
    chk(p1_rx_flags == 6'b110000, "R7 enable write keeps status", 32'(p1_rx_flags), 32'h30);
    idle();
    chk(p1_irq_rx == 1'b1, "R7 rx enable loaded", 32'(p1_irq_rx), 32'h1);

    // random traffic on both ports
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), NCH'($urandom),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), NCH'($urandom));
    end
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule